// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer with Serial Data Read

This block is the digital side of a multichannel converter as seen through its serial port. An external conversion-done strobe stands in for the modulator and filter timing. On each strobe the block takes the result for the channel it is currently pointing at from a sample input, places it in a data register together with its channel tag, and steps to the next channel whose enable bit is set. Channels whose bit is clear are skipped, so the pointer loops through the enabled set once per round.

A fresh result drives the active-low ready flag low. While chip select is low and no word is being shifted out, the serial output pin mirrors that flag, so a host can wait for a falling pin and then issue the read command. The host sends the data-read command byte, receives the data word most significant bit first, and optionally one status byte after it. When the last bit has gone out, the ready flag returns high. A result that arrives while a read is in progress is dropped, so the word being shifted out is never corrupted.

The serial port works in SPI mode 3: the clock idles high, the block samples its input on rising edges, and each output bit is valid before the rising edge that samples it. All port inputs pass through two-stage synchronisers onto the system clock. The read controller has five states. ST_IDLE means chip select is high. ST_CMD collects the command byte. ST_DATA shifts out the data word. ST_STAT shifts out the status byte. ST_SKIP ignores a command other than the data read. The transitions are as follows. ST_IDLE goes to ST_CMD when chip select goes low. ST_CMD goes to ST_DATA on the read command and to ST_SKIP on any other byte. ST_DATA goes to ST_STAT when the status byte is enabled, and otherwise back to ST_CMD. ST_STAT goes back to ST_CMD. From any state, chip select going high leads to ST_IDLE.

Top module: `chanseq_top`

## Requirements
- R1: After reset, rdy_n is 1, miso is 1 and conv_chan is 0.
- R2: conv_chan always names the first enabled channel at or after the internal pointer, in ascending order with wrap-around. Each accepted strobe moves the pointer to the channel after the one just converted, so disabled channels are skipped.
- R3: A conv_done pulse while at least one channel is enabled and no read is in progress latches sample into the data register, tags it with conv_chan, and drives rdy_n to 0 on the following clock.
- R4: While chan_en is all zeros, conv_done has no effect: conv_chan and rdy_n keep their values.
- R5: miso is 1 while cs_n is high. While cs_n is low and no word is being shifted out, miso equals rdy_n.
- R6: With cs_n low, the host sends command byte 0x58 MSB first on mosi, sampled on rising sclk. The block then presents the 24-bit data register MSB first, each bit valid before the rising sclk edge that reads it.
- R7: After the last bit of a read, rdy_n returns to 1, so with cs_n still low miso is 1. A repeated read returns the same word.
- R8: A conversion that completes during a read is discarded. The word being read, the data register and rdy_n are untouched, but the channel pointer still advances.
- R9: When append_status is 1 at the start of a read, 8 more bits follow the data word. Bit 7 is the rdy_n value at the start of the read, bits 6:0 are the channel tag of the word, and bits 6:2 are zero for four channels.
- R10: A command byte other than 0x58 starts no read. miso keeps mirroring rdy_n until cs_n goes high, and rdy_n is unchanged.
- R11: Raising cs_n in the middle of a read abandons it. rdy_n stays 0, and a later full read returns the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Channel enable mask, bit i enables channel i |
| append_status | input | 1 | Append the status byte after the data word |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| sample | input | DW | Conversion result for the channel on conv_chan |
| conv_chan | output | CW | Channel the next conversion belongs to |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial command input |
| miso | output | 1 | Serial data out, doubling as the ready pin |
| rdy_n | output | 1 | Ready flag, low when an unread result is waiting |

## Verification
Most wrong internal states here show up at the ports within one transaction. A bad channel pointer appears on conv_chan at once, and it appears in the status byte of the next read. A stuck or misset ready flag shows on miso as soon as chip select falls. A bit counter that is off by one shifts every bit of the returned word. The slower faults are a collision that wrongly updates the register and an abort that clears the flag. Neither is visible until the host reads the word back, so the bench re-reads after each of these cases.

// File: rtl/chanseq_pkg.sv
package chanseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_STAT,
        ST_SKIP
    } rd_state_t;
endpackage

// File: rtl/chanseq_sync.sv
module chanseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic cs_n_s,
    output logic mosi_s,
    output logic sclk_rise
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] stage_q [STAGES];
    logic            sclk_prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= {sclk_i, cs_n_i, mosi_i};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b1;
        else        sclk_prev_q <= stage_q[STAGES-1][2];
    end

    assign cs_n_s    = stage_q[STAGES-1][1];
    assign mosi_s    = stage_q[STAGES-1][0];
    assign sclk_rise = stage_q[STAGES-1][2] & ~sclk_prev_q;
endmodule

// File: rtl/chanseq_rr.sv
module chanseq_rr #(
    parameter int NCH = 4,
    parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic           conv_done,
    output logic [CW-1:0]  cur_chan,
    output logic           take
);
    logic [CW-1:0] ptr_q;

    function automatic logic [CW-1:0] first_at_or_after(input logic [CW-1:0] p,
                                                        input logic [NCH-1:0] m);
        logic [CW-1:0] res;
        logic          found;
        int            idx;
        res   = p;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            idx = int'(p) + k;
            if (idx >= NCH) idx = idx - NCH;
            if (!found && m[idx]) begin
                res   = CW'(idx);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    always_comb begin
        cur_chan = first_at_or_after(ptr_q, chan_en);
        take     = conv_done & (|chan_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take) begin
            if (int'(cur_chan) == NCH - 1) ptr_q <= '0;
            else                           ptr_q <= cur_chan + 1'b1;
        end
    end

    // R2
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_chan != $past(cur_chan)) || ($countones($past(chan_en)) == 1)
                 || (chan_en != $past(chan_en)));

    // R4
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && chan_en == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/chanseq_read_ctrl.sv
module chanseq_read_ctrl
    import chanseq_pkg::*;
#(
    parameter int          DW     = 24,
    parameter int          CW     = 2,
    parameter logic [7:0]  RD_CMD = 8'h58
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_raw,
    input  logic          cs_n_s,
    input  logic          sclk_rise,
    input  logic          mosi_s,
    input  logic          take,
    input  logic [CW-1:0] chan,
    input  logic [DW-1:0] sample,
    input  logic          append_status,
    output logic          miso,
    output logic          rdy_n_o
);
    localparam int SW   = DW + 8;
    localparam int CNTW = $clog2(DW) + 1;

    rd_state_t       state, nxt;
    logic [CNTW-1:0] cnt_q;
    logic [6:0]      cmd_q;
    logic [7:0]      cmd_full;
    logic [SW-1:0]   sh_q;
    logic [DW-1:0]   data_q;
    logic [CW-1:0]   chan_q;
    logic [7:0]      stat_b;
    logic            rdy_n_q;
    logic            app_q;
    logic            load;
    logic            reading;

    always_comb begin
        cmd_full  = {cmd_q, mosi_s};
        stat_b    = 8'(chan_q);
        stat_b[7] = rdy_n_q;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_n_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_CMD;
                ST_CMD:  if (sclk_rise && cnt_q == CNTW'(7))
                             nxt = (cmd_full == RD_CMD) ? ST_DATA : ST_SKIP;
                ST_DATA: if (sclk_rise && cnt_q == CNTW'(DW - 1))
                             nxt = app_q ? ST_STAT : ST_CMD;
                ST_STAT: if (sclk_rise && cnt_q == CNTW'(7))
                             nxt = ST_CMD;
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load    = (state == ST_CMD) && (nxt == ST_DATA);
        reading = (state == ST_DATA) || (state == ST_STAT) || load;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmd_q   <= '0;
            sh_q    <= '0;
            data_q  <= '0;
            chan_q  <= '0;
            rdy_n_q <= 1'b1;
            app_q   <= 1'b0;
        end else begin
            if (state != nxt)  cnt_q <= '0;
            else if (sclk_rise) cnt_q <= cnt_q + 1'b1;

            if (state == ST_CMD && sclk_rise) cmd_q <= cmd_full[6:0];

            if (load) begin
                sh_q  <= {data_q, stat_b};
                app_q <= append_status;
            end else if (reading && sclk_rise) begin
                sh_q <= {sh_q[SW-2:0], 1'b0};
            end

            if ((state == ST_DATA || state == ST_STAT) && nxt == ST_CMD) begin
                rdy_n_q <= 1'b1;
            end else if (take && !reading) begin
                rdy_n_q <= 1'b0;
                data_q  <= sample;
                chan_q  <= chan;
            end
        end
    end

    // outputs
    always_comb begin
        if (cs_n_raw)
            miso = 1'b1;
        else if (state == ST_DATA || state == ST_STAT)
            miso = sh_q[SW-1];
        else
            miso = rdy_n_q;
        rdy_n_o = rdy_n_q;
    end

    // R3
    fresh_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !reading) |=> !rdy_n_o);

    // R7
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n_o) |-> ($past(state) == ST_DATA || $past(state) == ST_STAT));

    // R8
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && reading) |=> ($stable(data_q) && $stable(chan_q)));

    // R10
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !cs_n_s) |=> (state == ST_SKIP || state == ST_IDLE));

    // R11
    abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && cs_n_s && !take) |=> $stable(rdy_n_o));
endmodule

// File: rtl/chanseq_top.sv
module chanseq_top #(
    parameter int         NCH    = 4,
    parameter int         DW     = 24,
    parameter logic [7:0] RD_CMD = 8'h58,
    parameter int         CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic           append_status,
    input  logic           conv_done,
    input  logic [DW-1:0]  sample,
    output logic [CW-1:0]  conv_chan,
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           mosi,
    output logic           miso,
    output logic           rdy_n
);
    logic cs_n_s, mosi_s, sclk_rise, take;

    chanseq_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .mosi_i    (mosi),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise)
    );

    chanseq_rr #(.NCH(NCH), .CW(CW)) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .conv_done (conv_done),
        .cur_chan  (conv_chan),
        .take      (take)
    );

    chanseq_read_ctrl #(.DW(DW), .CW(CW), .RD_CMD(RD_CMD)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n_raw      (cs_n),
        .cs_n_s        (cs_n_s),
        .sclk_rise     (sclk_rise),
        .mosi_s        (mosi_s),
        .take          (take),
        .chan          (conv_chan),
        .sample        (sample),
        .append_status (append_status),
        .miso          (miso),
        .rdy_n_o       (rdy_n)
    );
endmodule

// File: tb/test_chanseq_top.sv
module test_chanseq_top;
    localparam int NCH = 4;
    localparam int DW  = 24;
    localparam int CW  = 2;
    localparam int H   = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] chan_en;
    logic           append_status;
    logic           conv_done;
    logic [DW-1:0]  sample;
    logic [CW-1:0]  conv_chan;
    logic           sclk, cs_n, mosi, miso, rdy_n;

    int errors = 0;
    int checks = 0;

    int            m_ptr = 0;
    logic [DW-1:0] m_data = '0;
    int            m_chan = 0;
    logic          m_rdy_n = 1'b1;

    always #2.5 clk = ~clk;

    chanseq_top i_chanseq_top (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .append_status(append_status),
        .conv_done(conv_done), .sample(sample), .conv_chan(conv_chan),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .rdy_n(rdy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_chan(input int p, input logic [NCH-1:0] m);
        for (int k = 0; k < NCH; k++) begin
            if (m[(p + k) % NCH]) return (p + k) % NCH;
        end
        return p;
    endfunction

    task automatic model_step(input logic [DW-1:0] v, input bit in_read);
        int c;
        if (chan_en == '0) return;
        c = eff_chan(m_ptr, chan_en);
        if (!in_read) begin
            m_data  = v;
            m_chan  = c;
            m_rdy_n = 1'b0;
        end
        m_ptr = (c + 1) % NCH;
    endtask

    task automatic do_conv(input logic [DW-1:0] v);
        sample    = v;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        model_step(v, 1'b0);
        @(negedge clk);
    endtask

    task automatic spi_xfer(input logic [7:0] cmd, input int nrd, input int strobe_at,
                            input logic [DW-1:0] sv, output logic [31:0] rd);
        rd = '0;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0; mosi = cmd[i];
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        for (int i = 0; i < nrd; i++) begin
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            rd = {rd[30:0], miso};
            sclk = 1'b1;
            if (i == strobe_at) begin
                sample = sv; conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                model_step(sv, 1'b1);
                repeat (H - 1) @(negedge clk);
            end else begin
                repeat (H) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_set(input logic v);
        cs_n = v;
        repeat (H) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 rdy_n", 32'(rdy_n), 32'd1);
        check("R1 miso", 32'(miso), 32'd1);
        check("R1 conv_chan", 32'(conv_chan), 32'd0);
    endtask

    task automatic t_round;
        chan_en = 4'b1011;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check("R2 conv_chan", 32'(conv_chan), 32'(eff_chan(m_ptr, chan_en)));
            do_conv(24'h5A0000 + 24'(i * 24'h111));
            check("R3 rdy_n low", 32'(rdy_n), 32'd0);
            check("R5 miso cs high", 32'(miso), 32'd1);
        end
    endtask

    task automatic t_read;
        logic [31:0] rd;
        cs_set(1'b0);
        check("R5 miso mirrors ready", 32'(miso), 32'd0);
        spi_xfer(8'h58, 24, -1, '0, rd);
        check("R6 data word", rd, 32'(m_data));
        check("R7 rdy_n after read", 32'(rdy_n), 32'd1);
        check("R7 miso after read", 32'(miso), 32'd1);
        spi_xfer(8'h58, 24, -1, '0, rd);
        check("R7 reread word", rd, 32'(m_data));
        cs_set(1'b1);
    endtask

    task automatic t_none;
        logic [CW-1:0] c0;
        chan_en = '0;
        @(negedge clk);
        c0 = conv_chan;
        do_conv(24'hDEAD01);
        check("R4 conv_chan held", 32'(conv_chan), 32'(c0));
        check("R4 rdy_n held", 32'(rdy_n), 32'd1);
        chan_en = 4'b1011;
        @(negedge clk);
    endtask

    task automatic t_collide;
        logic [31:0] rd;
        do_conv(24'hA1B2C3);
        cs_set(1'b0);
        spi_xfer(8'h58, 24, 10, 24'h777777, rd);
        check("R8 word kept", rd, 32'h00A1B2C3);
        check("R8 rdy_n high", 32'(rdy_n), 32'd1);
        check("R8 pointer advanced", 32'(conv_chan), 32'(eff_chan(m_ptr, chan_en)));
        spi_xfer(8'h58, 24, -1, '0, rd);
        check("R8 register kept", rd, 32'h00A1B2C3);
        cs_set(1'b1);
    endtask

    task automatic t_status;
        logic [31:0] rd;
        append_status = 1'b1;
        do_conv(24'h13579B);
        cs_set(1'b0);
        spi_xfer(8'h58, 32, -1, '0, rd);
        check("R9 data part", 32'(rd[31:8]), 32'h0013579B);
        check("R9 status fresh", 32'(rd[7:0]), 32'(m_chan));
        spi_xfer(8'h58, 32, -1, '0, rd);
        check("R9 status reread", 32'(rd[7:0]), 32'h80 | 32'(m_chan));
        append_status = 1'b0;
        cs_set(1'b1);
    endtask

    task automatic t_badcmd;
        logic [31:0] rd;
        do_conv(24'h2468AC);
        cs_set(1'b0);
        spi_xfer(8'h5C, 24, -1, '0, rd);
        check("R10 miso mirrors ready", rd, 32'h0);
        check("R10 rdy_n unchanged", 32'(rdy_n), 32'd0);
        cs_set(1'b1);
    endtask

    task automatic t_abort;
        logic [31:0] rd;
        cs_set(1'b0);
        spi_xfer(8'h58, 8, -1, '0, rd);
        check("R11 partial bits", rd, 32'h24);
        cs_set(1'b1);
        check("R11 rdy_n after abort", 32'(rdy_n), 32'd0);
        cs_set(1'b0);
        spi_xfer(8'h58, 24, -1, '0, rd);
        check("R11 full read", rd, 32'h002468AC);
        check("R11 rdy_n after full read", 32'(rdy_n), 32'd1);
        cs_set(1'b1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; chan_en = '0; append_status = 1'b0; conv_done = 1'b0;
        sample = '0; sclk = 1'b1; cs_n = 1'b1; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_round();
        t_read();
        t_none();
        t_collide();
        t_status();
        t_badcmd();
        t_abort();
        finish_run();
    end
endmodule